// File: doc/BRIEF.md
# Two-Wire Serial Clock Timing Generator

This block makes the serial clock waveform for the master side of a two-wire (I2C) bus. It works in two stages. A 7-bit prescaler divides the system clock into a single-cycle reference tick, which software normally sets to about 10 MHz. A phase sequencer then counts those ticks to build each clock period. The low time and the high time come from the two bytes of a 16-bit divider word. Each half has its own count, so the duty cycle can be set freely.

The byte engine that drives data uses two single-cycle strobes from this block. One marks the last cycle of the low phase and the other marks the last cycle of the high phase. A mode input picks standard or fast timing. Each mode sets a minimum length for each phase, and a programmed count below that minimum is raised to it. While the generator releases the clock but the sensed line stays low, the slave is holding the clock. During that time the high-phase count waits. Dropping the enable releases the clock at once and clears all counting state. Setting the enable again starts a new low phase.

Top module: `scl_timing_gen`

## Requirements
- R1: While `enable` is high, `ref_tick` is a single-cycle pulse that repeats every max(`prescale`,1) clock cycles. While `enable` is low it stays at 0.
- R2: In steady state the clock is held low (`scl_out`=0) for eff_low × max(`prescale`,1) cycles. Here eff_low = max(`divider[7:0]`, low floor).
- R3: In steady state the clock is released (`scl_out`=1) for eff_high × max(`prescale`,1) cycles when not stretched. Here eff_high = max(`divider[15:8]`, high floor).
- R4: The floors are mode dependent. With `fast_mode`=0 the low floor is 47 ticks and the high floor is 40 ticks. With `fast_mode`=1 they are 13 and 6. A field of zero therefore gives the floor.
- R5: While `scl_out`=1 and `scl_sense`=0, the high-phase count does not advance and `high_done` stays low. Each such cycle lengthens the high phase by one cycle.
- R6: When `enable` is low, `scl_out` is 1 from the next cycle on, and no tick or strobe is issued. After `enable` rises again, `scl_out` goes to 0 after one clock edge and a full new low phase begins.
- R7: `low_done` pulses for one cycle, and `scl_out` rises on the next edge. `high_done` pulses for one cycle, and `scl_out` falls on the next edge. The two strobes are never high together, and each fires once per period.
- R8: After a synchronous reset, `scl_out`=1 and `ref_tick`, `low_done` and `high_done` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Runs the generator; low releases the clock and clears state |
| fast_mode | input | 1 | 1 selects fast-mode phase floors |
| prescale | input | 7 | System clocks per reference tick (0 acts as 1) |
| divider | input | 16 | [15:8] high ticks, [7:0] low ticks |
| scl_sense | input | 1 | Sensed level of the clock line |
| scl_out | output | 1 | 0 = pull the clock low, 1 = release |
| ref_tick | output | 1 | Single-cycle reference tick |
| low_done | output | 1 | Last cycle of the low phase |
| high_done | output | 1 | Last cycle of the high phase |

## Verification
The hardest case to create is clock stretching. The sensed line has to go low exactly while the generator is releasing the clock, starting at the very edge where the high phase begins. The bench derives the sense input from the block's own output and a forcing flag. It raises the flag on the cycle where `low_done` is seen, so the stall covers a known number of high-phase cycles. With a prescale of 1, the expected high width is then exact. Random runs also reprogram the mode, the divider and the prescale while the block is disabled. These runs cover the floor cases and the full-range counts.

// File: rtl/scl_timing_pkg.sv
package scl_timing_pkg;

    localparam int PHASE_W = 8;
    localparam int PRE_W   = 7;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOW  = 2'd1,
        PH_HIGH = 2'd2
    } scl_phase_e;

    typedef struct packed {
        logic [PHASE_W-1:0] high_ticks;
        logic [PHASE_W-1:0] low_ticks;
    } clk_div_t;

    // Phase length in ticks: programmed value raised to the floor, never below 1.
    function automatic logic [PHASE_W-1:0] phase_limit(
        input logic [PHASE_W-1:0] field,
        input logic [PHASE_W-1:0] floor_val
    );
        logic [PHASE_W-1:0] r;
        r = (field < floor_val) ? floor_val : field;
        if (r == '0) r = PHASE_W'(1);
        return r;
    endfunction

endpackage

// File: rtl/scl_ref_prescaler.sv
module scl_ref_prescaler #(
    parameter int PRE_W = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  logic [PRE_W-1:0] prescale,
    output logic             tick
);
    logic [PRE_W-1:0] div_cnt;
    logic [PRE_W-1:0] term;

    assign term = (prescale == '0) ? '0 : prescale - PRE_W'(1);
    assign tick = enable && (div_cnt >= term);

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            div_cnt <= '0;
        end else if (div_cnt >= term) begin
            div_cnt <= '0;
        end else begin
            div_cnt <= div_cnt + PRE_W'(1);
        end
    end
endmodule

// File: rtl/scl_phase_seq.sv
module scl_phase_seq
    import scl_timing_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               enable,
    input  logic               tick,
    input  logic               scl_sense,
    input  logic [PHASE_W-1:0] low_lim,
    input  logic [PHASE_W-1:0] high_lim,
    output logic               scl_out,
    output logic               low_done,
    output logic               high_done
);
    scl_phase_e         phase;
    logic [PHASE_W-1:0] cnt;
    logic               last_low;
    logic               last_high;

    assign last_low  = cnt >= (low_lim - PHASE_W'(1));
    assign last_high = cnt >= (high_lim - PHASE_W'(1));

    assign low_done  = (phase == PH_LOW)  && tick && last_low;
    assign high_done = (phase == PH_HIGH) && tick && scl_sense && last_high;
    assign scl_out   = (phase != PH_LOW);

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            phase <= PH_IDLE;
            cnt   <= '0;
        end else begin
            unique case (phase)
                PH_IDLE: begin
                    phase <= PH_LOW;
                    cnt   <= '0;
                end
                PH_LOW: begin
                    if (tick) begin
                        if (last_low) begin
                            phase <= PH_HIGH;
                            cnt   <= '0;
                        end else begin
                            cnt <= cnt + PHASE_W'(1);
                        end
                    end
                end
                PH_HIGH: begin
                    if (tick && scl_sense) begin
                        if (last_high) begin
                            phase <= PH_LOW;
                            cnt   <= '0;
                        end else begin
                            cnt <= cnt + PHASE_W'(1);
                        end
                    end
                end
                default: begin
                    phase <= PH_IDLE;
                    cnt   <= '0;
                end
            endcase
        end
    end
endmodule

// File: rtl/scl_timing_gen.sv
module scl_timing_gen
    import scl_timing_pkg::*;
#(
    parameter int STD_LOW_MIN   = 47,
    parameter int STD_HIGH_MIN  = 40,
    parameter int FAST_LOW_MIN  = 13,
    parameter int FAST_HIGH_MIN = 6
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 enable,
    input  logic                 fast_mode,
    input  logic [PRE_W-1:0]     prescale,
    input  logic [2*PHASE_W-1:0] divider,
    input  logic                 scl_sense,
    output logic                 scl_out,
    output logic                 ref_tick,
    output logic                 low_done,
    output logic                 high_done
);
    localparam int NPH = 2;
    localparam logic [NPH*PHASE_W-1:0] STD_FLOORS  =
        {PHASE_W'(STD_HIGH_MIN), PHASE_W'(STD_LOW_MIN)};
    localparam logic [NPH*PHASE_W-1:0] FAST_FLOORS =
        {PHASE_W'(FAST_HIGH_MIN), PHASE_W'(FAST_LOW_MIN)};

    clk_div_t           div_w;
    logic [PHASE_W-1:0] lim [NPH];
    logic [PHASE_W-1:0] fld [NPH];

    assign div_w  = clk_div_t'(divider);
    assign fld[0] = div_w.low_ticks;
    assign fld[1] = div_w.high_ticks;

    for (genvar g = 0; g < NPH; g++) begin : g_lim
        logic [PHASE_W-1:0] floor_sel;
        assign floor_sel = fast_mode ? FAST_FLOORS[g*PHASE_W +: PHASE_W]
                                     : STD_FLOORS[g*PHASE_W +: PHASE_W];
        assign lim[g] = phase_limit(fld[g], floor_sel);
    end

    scl_ref_prescaler #(.PRE_W(PRE_W)) i_pre (
        .clk      (clk),
        .rst      (rst),
        .enable   (enable),
        .prescale (prescale),
        .tick     (ref_tick)
    );

    scl_phase_seq i_seq (
        .clk       (clk),
        .rst       (rst),
        .enable    (enable),
        .tick      (ref_tick),
        .scl_sense (scl_sense),
        .low_lim   (lim[0]),
        .high_lim  (lim[1]),
        .scl_out   (scl_out),
        .low_done  (low_done),
        .high_done (high_done)
    );
endmodule

// File: rtl/scl_timing_gen_chk.sv
module scl_timing_gen_chk (
    input logic       clk,
    input logic       rst,
    input logic       enable,
    input logic [6:0] prescale,
    input logic       scl_sense,
    input logic       scl_out,
    input logic       ref_tick,
    input logic       low_done,
    input logic       high_done
);
    assert_tick_single_R1: assert property (@(posedge clk) disable iff (rst)
        (ref_tick && prescale > 7'd1) |=> (!ref_tick || !$stable(prescale)));

    assert_stretch_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (scl_out && !scl_sense) |-> !high_done);

    assert_disable_quiet_R6: assert property (@(posedge clk) disable iff (rst)
        !enable |-> (!ref_tick && !low_done && !high_done));

    assert_disable_release_R6: assert property (@(posedge clk) disable iff (rst)
        !enable |=> scl_out);

    assert_low_done_rise_R7: assert property (@(posedge clk) disable iff (rst)
        low_done |=> $rose(scl_out));

    assert_high_done_fall_R7: assert property (@(posedge clk) disable iff (rst)
        high_done |=> $fell(scl_out));

    assert_strobe_excl_R7: assert property (@(posedge clk) disable iff (rst)
        $onehot0({low_done, high_done}));
endmodule

bind scl_timing_gen scl_timing_gen_chk i_chk (
    .clk       (clk),
    .rst       (rst),
    .enable    (enable),
    .prescale  (prescale),
    .scl_sense (scl_sense),
    .scl_out   (scl_out),
    .ref_tick  (ref_tick),
    .low_done  (low_done),
    .high_done (high_done)
);

// File: tb/test_scl_timing_gen.sv
module test_scl_timing_gen;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        enable = 1'b0;
    logic        fast_mode = 1'b0;
    logic [6:0]  prescale = 7'd1;
    logic [15:0] divider = 16'h0000;
    logic        force_low = 1'b0;
    logic        scl_sense;
    logic        scl_out, ref_tick, low_done, high_done;

    int n_checks = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    assign scl_sense = scl_out & ~force_low;

    scl_timing_gen i_scl_timing_gen (
        .clk(clk), .rst(rst), .enable(enable), .fast_mode(fast_mode),
        .prescale(prescale), .divider(divider), .scl_sense(scl_sense),
        .scl_out(scl_out), .ref_tick(ref_tick), .low_done(low_done),
        .high_done(high_done)
    );

    function automatic int eff(input int field, input int floor_val);
        return (field < floor_val) ? floor_val : field;
    endfunction

    function automatic int pmul(input int p);
        return (p == 0) ? 1 : p;
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wait_fall();
        logic prev;
        prev = scl_out;
        forever begin
            @(negedge clk);
            if (prev && !scl_out) break;
            prev = scl_out;
        end
    endtask

    // Called just after a fall is seen; returns low and high widths in cycles.
    task automatic measure(output int lo, output int hi);
        lo = 0; hi = 0;
        while (!scl_out) begin lo++; @(negedge clk); end
        while (scl_out) begin hi++; @(negedge clk); end
    endtask

    task automatic configure(input bit fm, input int p, input int lo_f, input int hi_f);
        @(negedge clk);
        enable = 1'b0;
        @(negedge clk);
        fast_mode = fm;
        prescale = 7'(p);
        divider = {8'(hi_f), 8'(lo_f)};
        @(negedge clk);
        enable = 1'b1;
    endtask

    task automatic run_period(input bit fm, input int p, input int lo_f, input int hi_f,
                              input string tag);
        int lo, hi, el, eh;
        configure(fm, p, lo_f, hi_f);
        el = eff(lo_f, fm ? 13 : 47) * pmul(p);
        eh = eff(hi_f, fm ? 6 : 40) * pmul(p);
        wait_fall();
        wait_fall();
        measure(lo, hi);
        check(lo == el, {tag, " R2 low width"}, lo, el);
        check(hi == eh, {tag, " R3 high width"}, hi, eh);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        int seed, cnt, lo, hi, ld, hd;
        logic prev;
        seed = $urandom(32'd915);

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R8: reset state
        check(scl_out == 1'b1, "R8 scl after reset", int'(scl_out), 1);
        check({ref_tick, low_done, high_done} == 3'b000, "R8 strobes after reset",
              int'({ref_tick, low_done, high_done}), 0);

        // R1: tick rate
        prescale = 7'd5;
        divider = 16'h3232;
        enable = 1'b1;
        cnt = 0;
        for (int i = 0; i < 100; i++) begin @(negedge clk); if (ref_tick) cnt++; end
        check(cnt == 20, "R1 tick count prescale 5", cnt, 20);
        prescale = 7'd0;
        @(negedge clk);
        cnt = 0;
        for (int i = 0; i < 50; i++) begin @(negedge clk); if (ref_tick) cnt++; end
        check(cnt == 50, "R1 tick count prescale 0", cnt, 50);

        // R6: disabled quiet and released
        enable = 1'b0;
        @(negedge clk);
        cnt = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (ref_tick || low_done || high_done || !scl_out) cnt++;
        end
        check(cnt == 0, "R6 activity while disabled", cnt, 0);

        // R2/R3 directed
        run_period(1'b0, 2, 60, 50, "dir std");
        run_period(1'b1, 3, 20, 9, "dir fast");
        // R4 floors
        run_period(1'b0, 1, 0, 0, "R4 std zero");
        run_period(1'b1, 1, 5, 200, "R4 fast low floor");
        run_period(1'b1, 2, 0, 0, "R4 fast zero");
        run_period(1'b0, 1, 255, 255, "max counts");

        // random
        for (int k = 0; k < 8; k++) begin
            run_period(1'($urandom), int'($urandom_range(0, 3)),
                       int'($urandom_range(0, 255)), int'($urandom_range(0, 255)),
                       "random");
        end

        // R7: strobe placement over one period
        configure(1'b0, 2, 50, 45);
        wait_fall();
        ld = 0; hd = 0; cnt = 0;
        prev = scl_out;
        while (ld == 0 || scl_out || prev) begin
            if (low_done) begin
                ld++;
                @(negedge clk);
                if (!(scl_out && !prev)) cnt++;
            end else if (high_done) begin
                hd++;
                @(negedge clk);
                if (!(!scl_out && prev)) cnt++;
            end else begin
                @(negedge clk);
            end
            prev = scl_out;
            if (ld > 0 && hd > 0 && !scl_out) break;
        end
        check(ld == 1, "R7 low_done pulses per period", ld, 1);
        check(hd == 1, "R7 high_done pulses per period", hd, 1);
        check(cnt == 0, "R7 strobe to edge alignment errors", cnt, 0);

        // R5: stretch with prescale 1, 31-cycle force from low_done
        configure(1'b0, 1, 50, 45);
        wait_fall();
        while (!low_done) @(negedge clk);
        force_low = 1'b1;
        hi = 0;
        for (int k = 0; k < 31; k++) begin @(negedge clk); if (scl_out) hi++; end
        force_low = 1'b0;
        while (scl_out) begin @(negedge clk); if (scl_out) hi++; end
        check(hi == 45 + 30, "R5 stretched high width", hi, 75);
        wait_fall();
        measure(lo, hi);
        check(hi == 45, "R5 unstretched high after stretch", hi, 45);

        // R6: disable mid-low, then restart
        configure(1'b0, 1, 100, 60);
        wait_fall();
        repeat (10) @(negedge clk);
        enable = 1'b0;
        @(negedge clk);
        check(scl_out == 1'b1, "R6 release after disable", int'(scl_out), 1);
        enable = 1'b1;
        @(negedge clk);
        check(scl_out == 1'b0, "R6 low after re-enable", int'(scl_out), 0);
        lo = 0;
        while (!scl_out) begin lo++; @(negedge clk); end
        check(lo >= 100 && lo <= 101, "R6 fresh full low phase", lo, 100);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule